// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block opens and closes the transmit gates of a set of egress queues on a repeating timetable. The timetable is a list of entries. Each entry gives the set of queues allowed to send and the cycle-relative time at which that window ends. A free-running nanosecond time input paces the block. It tracks where the current cycle started and selects the entry whose window covers the present instant. The selected mask is registered onto `gate_mask`, so it appears one clock after the time value that produced it.

Two copies of the list are kept. One is active and one is a shadow. Software fills the shadow copy through a write port while the active copy keeps running. It then raises a change request and issues a trigger that carries the new cycle time, the entry count, the absolute switch time and an extension threshold. At the switch time the two copies exchange roles. The change and pending flags drop, and `swap_done` pulses for one clock.

The new schedule may not begin on a boundary of the old cycle. In that case the threshold decides what happens to the final, shortened old cycle. Either it never starts and the previous gate state is held, or it runs and is cut off at the switch time. A configuration whose cycle time or entry count is out of range is refused, and the refusal is flagged.

Top module: `gate_sched_engine`

## Requirements
- R1: While `enable` is low, and after enable until the first switch time is reached, `gate_mask` is all ones. Dropping `enable` also clears the change, pending and error flags.
- R2: With cycle start S and cycle time C, the relative time is `(time_ns - S) mod C`. `gate_mask` takes the mask of the lowest-index valid entry whose end time is greater than the relative time. If no valid entry qualifies, the mask of the last valid entry is held until the cycle ends. The output is registered one clock after the time sample.
- R3: Accepting a trigger marks the shadow entries with index at or above `cfg_count` as unused. Unused entries never drive `gate_mask`, whatever their stored content.
- R4: Writes through `wr_en`/`wr_idx` land only in the shadow list and leave the running output unchanged.
- R5: `chg_req` sets `cfg_change` and `cfg_pending` and clears `cfg_error`. The swap happens at the first clock whose sampled time is at or past `cfg_base`. In that clock `swap_done` is high for exactly one cycle and both flags read low, and the new list starts at relative time zero.
- R6: For each queue q, `close_times[q*TIME_W +: TIME_W]` gives the end time of the last active entry that opens q. If that entry is the last valid one, the value is the cycle time. If no entry opens q, the value is 0.
- R7: Let r be the distance from the start of the last old cycle to the switch time. If r is shorter than both the old cycle time and `cfg_ext`, that cycle does not start. `gate_mask` keeps the mask from the end of the previous cycle until the switch.
- R8: If r is at least `cfg_ext`, the last old cycle runs normally and is truncated at the switch time.
- R9: A trigger with the cycle time outside `[MIN_CYCLE, MAX_CYCLE]`, or with `cfg_count` equal to zero or above `NUM_ENTRIES`, sets `cfg_error`, clears both flags and never causes a swap.
- R10: A trigger while no request is pending is ignored: no swap and no change of `cfg_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low forces gates open |
| time_ns | input | TIME_W | Free-running nanosecond time |
| wr_en | input | 1 | Shadow entry write strobe |
| wr_idx | input | IDX_W | Shadow entry index |
| wr_mask | input | NUM_QUEUES | Gate-open mask for the entry |
| wr_end | input | TIME_W | Window end time, cycle-relative |
| cfg_cycle | input | TIME_W | New cycle time |
| cfg_base | input | TIME_W | Absolute switch time |
| cfg_ext | input | TIME_W | Extension threshold for the last old cycle |
| cfg_count | input | CNT_W | Number of valid entries in the new list |
| chg_req | input | 1 | Sets change and pending flags |
| trigger | input | 1 | Validates and arms the pending change |
| gate_mask | output | NUM_QUEUES | Per-queue transmit gate, 1 = open |
| cfg_change | output | 1 | Change in progress, cleared at swap |
| cfg_pending | output | 1 | Change requested, cleared at swap |
| cfg_error | output | 1 | Last trigger carried an illegal configuration |
| swap_done | output | 1 | One-cycle pulse at the list swap |
| close_times | output | NUM_QUEUES*TIME_W | Per-queue gate close time in the active cycle |

## Verification
The hardest case to reach is the held final cycle. The switch time must land a few nanoseconds past a boundary of the running schedule, with the threshold above that gap. It must also be armed before that boundary passes. The stimulus therefore computes the switch time from the running base and cycle, placing it three cycles ahead plus a small offset. The truncation case uses a larger offset. Every clock through both switchovers is compared against an arithmetic model of the cycle position.

// File: rtl/gse_pkg.sv
package gse_pkg;
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_RUN  = 2'd1,
        GS_HOLD = 2'd2
    } gse_mode_e;
endpackage

// File: rtl/gse_bank.sv
module gse_bank #(
    parameter int NE = 16,
    parameter int QN = 8,
    parameter int TW = 32,
    localparam int IW = $clog2(NE),
    localparam int CW = $clog2(NE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_sel,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [QN-1:0] wr_mask,
    input  logic [TW-1:0] wr_end,
    input  logic          arm,
    input  logic [CW-1:0] arm_cnt,
    input  logic          rd_sel,
    output logic [QN-1:0] rd_mask [NE],
    output logic [TW-1:0] rd_end  [NE],
    output logic [NE-1:0] rd_valid
);
    logic [QN-1:0] mask_q  [2][NE];
    logic [TW-1:0] end_q   [2][NE];
    logic [NE-1:0] valid_q [2];

    // shadow bank is always the one not selected as active
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mask_q[~act_sel][wr_idx] <= wr_mask;
            end_q[~act_sel][wr_idx]  <= wr_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q[0] <= '0;
            valid_q[1] <= '0;
        end else if (arm) begin
            for (int i = 0; i < NE; i++)
                valid_q[~act_sel][i] <= (CW'(i) < arm_cnt);
        end
    end

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            rd_mask[i] = mask_q[rd_sel][i];
            rd_end[i]  = end_q[rd_sel][i];
        end
        rd_valid = valid_q[rd_sel];
    end
endmodule

// File: rtl/gse_lookup.sv
module gse_lookup #(
    parameter int NE = 16,
    parameter int QN = 8,
    parameter int TW = 32
) (
    input  logic [TW-1:0] rel,
    input  logic [QN-1:0] mask  [NE],
    input  logic [TW-1:0] wend  [NE],
    input  logic [NE-1:0] valid,
    output logic [QN-1:0] sel_mask
);
    logic [QN-1:0] tail_mask;

    always_comb begin
        tail_mask = '0;
        for (int i = 0; i < NE; i++)
            if (valid[i]) tail_mask = mask[i];
        sel_mask = tail_mask;
        for (int i = NE - 1; i >= 0; i--)
            if (valid[i] && (rel < wend[i])) sel_mask = mask[i];
    end
endmodule

// File: rtl/gse_close.sv
module gse_close #(
    parameter int NE = 16,
    parameter int QN = 8,
    parameter int TW = 32
) (
    input  logic [QN-1:0]    mask  [NE],
    input  logic [TW-1:0]    wend  [NE],
    input  logic [NE-1:0]    valid,
    input  logic [TW-1:0]    cycle,
    output logic [QN*TW-1:0] close
);
    logic [NE-1:0] is_last;
    assign is_last = valid & ~(valid >> 1);

    for (genvar q = 0; q < QN; q++) begin : g_queue
        logic [TW-1:0] ct;
        always_comb begin
            ct = '0;
            for (int i = 0; i < NE; i++)
                if (valid[i] && mask[i][q])
                    ct = is_last[i] ? cycle : wend[i];
        end
        assign close[q*TW +: TW] = ct;
    end
endmodule

// File: rtl/gate_sched_engine.sv
module gate_sched_engine #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_QUEUES  = 8,
    parameter int TIME_W      = 32,
    parameter int MIN_CYCLE   = 8,
    parameter int MAX_CYCLE   = 1000000000,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic [TIME_W-1:0]            time_ns,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [NUM_QUEUES-1:0]        wr_mask,
    input  logic [TIME_W-1:0]            wr_end,
    input  logic [TIME_W-1:0]            cfg_cycle,
    input  logic [TIME_W-1:0]            cfg_base,
    input  logic [TIME_W-1:0]            cfg_ext,
    input  logic [CNT_W-1:0]             cfg_count,
    input  logic                         chg_req,
    input  logic                         trigger,
    output logic [NUM_QUEUES-1:0]        gate_mask,
    output logic                         cfg_change,
    output logic                         cfg_pending,
    output logic                         cfg_error,
    output logic                         swap_done,
    output logic [NUM_QUEUES*TIME_W-1:0] close_times
);
    import gse_pkg::*;

    typedef struct packed {
        gse_mode_e                   mode;
        logic                        sel;
        logic                        armed;
        logic                        chg;
        logic                        pend;
        logic                        err;
        logic                        done;
        logic [NUM_QUEUES-1:0]       gate;
        logic [TIME_W-1:0]           cs;
        logic [TIME_W-1:0]           a_cyc;
        logic [TIME_W-1:0]           n_cyc;
        logic [TIME_W-1:0]           n_base;
        logic [TIME_W-1:0]           n_ext;
        logic [NUM_QUEUES*TIME_W-1:0] close;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_QUEUES-1:0] bk_mask [NUM_ENTRIES];
    logic [TIME_W-1:0]     bk_end  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] bk_valid;
    logic [NUM_QUEUES-1:0] lk_mask;
    logic [NUM_QUEUES*TIME_W-1:0] cl_vec;

    logic [TIME_W-1:0] rel_raw, rel_run, rel_use, cs_adv, rem, to_base, cyc_nxt;
    logic              wrap, hit, sel_nxt, cfg_ok, arm;

    // cycle position and switch detection, all from registered state
    assign rel_raw = time_ns - s_q.cs;
    assign wrap    = (rel_raw >= s_q.a_cyc);
    assign cs_adv  = wrap ? s_q.cs + s_q.a_cyc : s_q.cs;
    assign rel_run = wrap ? rel_raw - s_q.a_cyc : rel_raw;
    assign to_base = time_ns - s_q.n_base;
    assign hit     = s_q.armed && !to_base[TIME_W-1];
    assign sel_nxt = hit ? ~s_q.sel : s_q.sel;
    assign cyc_nxt = hit ? s_q.n_cyc : s_q.a_cyc;
    assign rel_use = hit ? to_base : rel_run;
    assign rem     = s_q.n_base - cs_adv;
    assign cfg_ok  = (cfg_cycle >= TIME_W'(MIN_CYCLE)) && (cfg_cycle <= TIME_W'(MAX_CYCLE))
                  && (cfg_count != '0) && (cfg_count <= CNT_W'(NUM_ENTRIES));
    assign arm     = enable && !chg_req && trigger && s_q.pend && !s_q.armed && cfg_ok;

    gse_bank #(.NE(NUM_ENTRIES), .QN(NUM_QUEUES), .TW(TIME_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .act_sel(s_q.sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_end(wr_end),
        .arm(arm), .arm_cnt(cfg_count), .rd_sel(sel_nxt),
        .rd_mask(bk_mask), .rd_end(bk_end), .rd_valid(bk_valid)
    );

    gse_lookup #(.NE(NUM_ENTRIES), .QN(NUM_QUEUES), .TW(TIME_W)) u_lookup (
        .rel(rel_use), .mask(bk_mask), .wend(bk_end), .valid(bk_valid), .sel_mask(lk_mask)
    );

    gse_close #(.NE(NUM_ENTRIES), .QN(NUM_QUEUES), .TW(TIME_W)) u_close (
        .mask(bk_mask), .wend(bk_end), .valid(bk_valid), .cycle(cyc_nxt), .close(cl_vec)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.sel   = sel_nxt;
        s_d.close = cl_vec;

        if (chg_req) begin
            s_d.chg  = 1'b1;
            s_d.pend = 1'b1;
            s_d.err  = 1'b0;
        end else if (trigger && s_q.pend && !s_q.armed) begin
            if (cfg_ok) begin
                s_d.armed  = 1'b1;
                s_d.n_cyc  = cfg_cycle;
                s_d.n_base = cfg_base;
                s_d.n_ext  = cfg_ext;
            end else begin
                s_d.err  = 1'b1;
                s_d.chg  = 1'b0;
                s_d.pend = 1'b0;
            end
        end

        if (hit) begin
            s_d.mode  = GS_RUN;
            s_d.a_cyc = s_q.n_cyc;
            s_d.cs    = s_q.n_base;
            s_d.armed = 1'b0;
            s_d.chg   = 1'b0;
            s_d.pend  = 1'b0;
            s_d.done  = 1'b1;
        end else if (s_q.mode == GS_RUN) begin
            s_d.cs = cs_adv;
            // last old cycle too short: do not start it, keep prior gates
            if (wrap && s_q.armed && (rem < s_q.a_cyc) && (rem < s_q.n_ext))
                s_d.mode = GS_HOLD;
        end

        case (s_d.mode)
            GS_RUN:  s_d.gate = lk_mask;
            GS_HOLD: s_d.gate = s_q.gate;
            default: s_d.gate = '1;
        endcase

        if (!enable) begin
            s_d.mode  = GS_IDLE;
            s_d.armed = 1'b0;
            s_d.chg   = 1'b0;
            s_d.pend  = 1'b0;
            s_d.err   = 1'b0;
            s_d.done  = 1'b0;
            s_d.gate  = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= GS_IDLE;
            s_q.gate <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_mask   = s_q.gate;
    assign cfg_change  = s_q.chg;
    assign cfg_pending = s_q.pend;
    assign cfg_error   = s_q.err;
    assign swap_done   = s_q.done;
    assign close_times = s_q.close;

    p_idle_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_mask == '1));

    p_swap_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> (!cfg_change && !cfg_pending));

    p_swap_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |=> !swap_done);

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == GS_HOLD) && $past(s_q.mode == GS_HOLD)) |-> $stable(gate_mask));

    p_err_noswap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_error) |-> !swap_done);

    p_trig_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trigger && !chg_req && !cfg_pending) |=> $stable(cfg_error));
endmodule

// File: tb/tb_gate_sched_engine.sv
module tb_gate_sched_engine;
    localparam int NE = 16;
    localparam int QN = 8;
    localparam int TW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n, enable, wr_en, chg_req, trigger;
    logic [TW-1:0]  tnow, wr_end, cfg_cycle, cfg_base, cfg_ext;
    logic [3:0]     wr_idx;
    logic [QN-1:0]  wr_mask;
    logic [4:0]     cfg_count;
    logic [QN-1:0]  gate_mask;
    logic           cfg_change, cfg_pending, cfg_error, swap_done;
    logic [QN*TW-1:0] close_times;

    gate_sched_engine #(.NUM_ENTRIES(NE), .NUM_QUEUES(QN), .TIME_W(TW),
                        .MIN_CYCLE(8), .MAX_CYCLE(100000)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .time_ns(tnow),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_end(wr_end),
        .cfg_cycle(cfg_cycle), .cfg_base(cfg_base), .cfg_ext(cfg_ext), .cfg_count(cfg_count),
        .chg_req(chg_req), .trigger(trigger),
        .gate_mask(gate_mask), .cfg_change(cfg_change), .cfg_pending(cfg_pending),
        .cfg_error(cfg_error), .swap_done(swap_done), .close_times(close_times)
    );

    int n_chk = 0, n_fail = 0;
    string g_tag = "R1";

    int a_mask[NE], a_end[NE], a_cnt, a_cyc, a_base;
    int n_mask[NE], n_end[NE], n_cnt, n_cyc, n_base;
    int p_mask[NE], p_end[NE];
    bit m_en, m_run, m_armed, m_hplan;
    int m_ls, m_hmask;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, tnow);
        end
    endtask

    function automatic int fmask(int rel);
        for (int i = 0; i < a_cnt; i++)
            if (rel < a_end[i]) return a_mask[i];
        return a_mask[a_cnt-1];
    endfunction

    task automatic tick;
        int tc, eg;
        bit hold_now, esw;
        @(posedge clk);
        #2;
        tc = int'(tnow);
        esw = 1'b0;
        hold_now = 1'b0;
        if (!m_en) begin m_run = 0; m_armed = 0; end
        if (m_armed && tc >= n_base) begin
            for (int i = 0; i < NE; i++) begin a_mask[i] = n_mask[i]; a_end[i] = n_end[i]; end
            a_cnt = n_cnt; a_cyc = n_cyc; a_base = n_base;
            m_run = 1; m_armed = 0; esw = 1'b1;
        end else if (m_armed && m_hplan && tc >= m_ls) begin
            hold_now = 1'b1;
        end
        eg = !m_run ? 'hFF : hold_now ? m_hmask : fmask((tc - a_base) % a_cyc);
        chk(g_tag, 64'(gate_mask), 64'(eg));
        chk("R5 swap_done", 64'(swap_done), 64'(esw));
        if (esw) begin
            chk("R5 change cleared at swap", 64'(cfg_change), 64'd0);
            chk("R5 pending cleared at swap", 64'(cfg_pending), 64'd0);
        end
        tnow = tnow + 1;
    endtask

    task automatic run(int n);
        repeat (n) tick();
    endtask

    task automatic put(int idx, int m, int e);
        p_mask[idx] = m; p_end[idx] = e;
        wr_en = 1'b1; wr_idx = 4'(idx); wr_mask = 8'(m); wr_end = TW'(e);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic request(int cyc, int base, int ext, int cnt, bit ok);
        int r;
        chg_req = 1'b1;
        tick();
        chg_req = 1'b0;
        chk("R5 change set", 64'(cfg_change), 64'd1);
        chk("R5 pending set", 64'(cfg_pending), 64'd1);
        chk("R5 error cleared by request", 64'(cfg_error), 64'd0);
        cfg_cycle = TW'(cyc); cfg_base = TW'(base); cfg_ext = TW'(ext); cfg_count = 5'(cnt);
        trigger = 1'b1;
        tick();
        trigger = 1'b0;
        if (ok) begin
            for (int i = 0; i < NE; i++) begin n_mask[i] = p_mask[i]; n_end[i] = p_end[i]; end
            n_cnt = cnt; n_cyc = cyc; n_base = base; m_armed = 1;
            m_hplan = 0;
            if (m_run) begin
                m_ls = a_base + ((base - 1 - a_base) / a_cyc) * a_cyc;
                r = base - m_ls;
                m_hplan = (r < a_cyc) && (r < ext);
                m_hmask = fmask(a_cyc - 1);
            end
            chk("R5 change held until swap", 64'(cfg_change), 64'd1);
        end else begin
            chk("R9 error flagged", 64'(cfg_error), 64'd1);
            chk("R9 change dropped", 64'(cfg_change), 64'd0);
            chk("R9 pending dropped", 64'(cfg_pending), 64'd0);
        end
    endtask

    task automatic chk_close(string tag);
        int e;
        for (int q = 0; q < QN; q++) begin
            e = 0;
            for (int i = 0; i < a_cnt; i++)
                if (a_mask[i][q]) e = (i == a_cnt - 1) ? a_cyc : a_end[i];
            chk(tag, 64'(close_times[q*TW +: TW]), 64'(e));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int nb;
        rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0; chg_req = 1'b0; trigger = 1'b0;
        tnow = 100; wr_idx = '0; wr_mask = '0; wr_end = '0;
        cfg_cycle = '0; cfg_base = '0; cfg_ext = '0; cfg_count = '0;
        m_en = 0; m_run = 0; m_armed = 0; m_hplan = 0;
        a_cnt = 1; a_cyc = 1; a_base = 0; a_mask[0] = 'hFF; a_end[0] = 0;
        g_tag = "R1 reset";
        run(3);
        rst_n = 1'b1;
        run(2);
        chk("R1 reset change", 64'(cfg_change), 64'd0);
        chk("R1 reset pending", 64'(cfg_pending), 64'd0);
        chk("R1 reset error", 64'(cfg_error), 64'd0);

        // first schedule; a stale entry sits beyond the count (R3)
        enable = 1'b1; m_en = 1;
        g_tag = "R1 open before first base";
        put(3, 'h55, 35);
        put(0, 'h01, 10); put(1, 'h06, 25); put(2, 'h80, 30);
        request(40, int'(tnow) + 30, 0, 3, 1);
        g_tag = "R2 R3 gate sequence";
        run(150);
        chk_close("R6 close times list A");

        // shadow writes while A runs must not disturb it (R4)
        g_tag = "R4 shadow write isolation";
        put(0, 'h0F, 12); put(1, 'hF0, 30); put(2, 'h99, 5);
        nb = a_base + ((int'(tnow) - a_base) / a_cyc + 3) * a_cyc + 5;
        request(30, nb, 8, 2, 1);
        g_tag = "R7 hold of short last cycle";
        while (int'(tnow) < nb + 70) tick();
        chk_close("R6 close times list B");

        put(0, 'hAA, 8); put(1, 'h55, 16); put(2, 'h3C, 20);
        nb = a_base + ((int'(tnow) - a_base) / a_cyc + 3) * a_cyc + 15;
        request(24, nb, 8, 3, 1);
        g_tag = "R8 truncated last cycle";
        while (int'(tnow) < nb + 60) tick();
        chk_close("R6 close times list C");

        g_tag = "R9 no swap on bad config";
        request(4, int'(tnow) + 20, 0, 2, 0);
        run(40);
        request(200000, int'(tnow) + 20, 0, 2, 0);
        run(10);
        request(30, int'(tnow) + 20, 0, 17, 0);
        run(10);
        request(30, int'(tnow) + 20, 0, 0, 0);
        run(40);

        g_tag = "R10 stray trigger";
        cfg_cycle = 30; cfg_base = tnow + 10; cfg_ext = 0; cfg_count = 2;
        trigger = 1'b1;
        tick();
        trigger = 1'b0;
        chk("R10 error unchanged", 64'(cfg_error), 64'd1);
        chk("R10 pending stays low", 64'(cfg_pending), 64'd0);
        run(40);

        g_tag = "R1 disabled gates open";
        enable = 1'b0; m_en = 0;
        run(5);
        chk("R1 disable clears error", 64'(cfg_error), 64'd0);
        enable = 1'b1; m_en = 1;
        g_tag = "R1 open before restart base";
        put(0, 'hAA, 8); put(1, 'h55, 16); put(2, 'h3C, 20);
        request(24, int'(tnow) + 20, 0, 3, 1);
        g_tag = "R2 restart sequence";
        run(70);
        chk_close("R6 close times after restart");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule